// File: doc/BRIEF.md
# SMRAM Access Window Controller

This block sits in a host bridge. For every memory access it decides whether the access goes to DRAM or falls through to the PCI/graphics side, based on whether the address lies in a system-management RAM window. There are three such windows:

- a fixed low window of 128 KB at 0xA0000 to 0xBFFFF;
- an optional copy of that window relocated above 1 MB, at 0x100A0000;
- an optional segment taken from the top of main memory.

Two byte-wide configuration registers control the policy. A requester in system-management mode may be let through, an explicit open or close override may apply, or a sticky lock may freeze the window closed. A sticky error flag records any illegal touch of the extended windows.

Configuration writes and reads use a simple byte port:

- a write takes effect at the clock edge;
- a read returns the selected register combinationally.

Accesses are presented with a valid strobe, an address and an SMM indicator. The routing decision appears on registered outputs one clock later.

Top module: `smram_window_ctrl`

## Requirements
- R1: After a synchronous active-low reset:
  - the control register (offset 0x72) reads 0x02 and the extended register (offset 0x73) reads 0x00;
  - dec_valid, route_dram and route_pci are low.
- R2: Reading offset 0x72 returns {0, open(bit 6), close(bit 5), lock(bit 4), global enable(bit 3), base code(bits 2:0)}. Reading offset 0x73 returns {high enable(bit 7), error(bit 6), 000, segment size code(bits 2:1), segment enable(bit 0)}. The base code always reads 2 and writes to it are ignored. Any other offset reads 0.
- R3: An access with acc_valid high produces, one cycle later, dec_valid high and exactly one of route_dram and route_pci high. With acc_valid low, all three outputs are low. Addresses outside every enabled window route to DRAM. The low window covers 0xA0000 through 0xBFFFF inclusive.
- R4: With the global enable clear, every access inside an enabled window routes to PCI, in or out of SMM.
- R5: With open set, window accesses route to DRAM whether or not acc_smm is high.
- R6: With open clear, accesses inside a window behave as follows:
  - if close is set, they route to PCI even when acc_smm is high;
  - if close is clear, they route to DRAM only when acc_smm is high.
- R7: When the high enable is set, 0x100A0000 through 0x100BFFFF is a window. When it is clear, that range routes to DRAM like ordinary memory.
- R8: When the segment enable is set, the window is the range [tom − size, tom − 1]. Size code 0 gives 128 KB, code 1 gives 256 KB and code 2 gives 512 KB. Code 3 disables the segment.
- R9: The error flag behaves as follows:
  - it is set by a valid access hitting the high window or the top segment while open is clear;
  - it stays set until a write to 0x73 with bit 6 high clears it;
  - if a set and a clear happen in the same cycle, the set wins.
- R10: Locking works as follows:
  - writing lock as 1 sets it until reset and clears open in the same write;
  - while locked, writes cannot change open or lock;
  - close and the global enable stay writable.
- R11: A control write with open and close both 1 leaves open unchanged and still updates the other fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data for cfg_addr (combinational) |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access byte address |
| acc_smm | input | 1 | Requester is in system-management mode |
| tom | input | 32 | Top of main memory (exclusive) |
| dec_valid | output | 1 | Decision valid, one cycle after acc_valid |
| route_dram | output | 1 | Access goes to DRAM |
| route_pci | output | 1 | Access goes to PCI |

## Verification
The assertions assume the following about the inputs:
- tom is at least 512 KB, so the stolen segment never wraps below zero;
- tom does not overlap the fixed windows in a way that makes one address hit two windows with conflicting error behaviour;
- reset is held for at least one clock before any checked cycle.

The stimulus keeps tom at 0x08000000 throughout and starts with several reset cycles. It then drives directed sequences at every window edge and mixes them with a pseudo-random run. That run draws its addresses only from window edges, window interiors and ordinary memory.

// File: rtl/smram_pkg.sv
// Package: shared offsets, field positions and register record types for
// the SMRAM access window controller.
package smram_pkg;

    localparam logic [7:0] CTL_OFS = 8'h72;
    localparam logic [7:0] EXT_OFS = 8'h73;

    // control register field positions
    localparam int CTL_OPEN  = 6;
    localparam int CTL_CLOSE = 5;
    localparam int CTL_LOCK  = 4;
    localparam int CTL_GEN   = 3;
    localparam logic [2:0] BASE_CODE = 3'd2;

    // extended register field positions
    localparam int EXT_HI  = 7;
    localparam int EXT_ERR = 6;
    localparam int EXT_SZ  = 1;
    localparam int EXT_TS  = 0;

    typedef struct packed {
        logic open;
        logic close;
        logic lock;
        logic gen_en;
    } ctl_t;

    typedef struct packed {
        logic       hi_en;
        logic       err;
        logic [1:0] tsz;
        logic       ts_en;
    } ext_t;

endpackage

// File: rtl/smram_regs.sv
// Module: smram_regs
// Holds the control and extended control registers, applies lock, dual
// open/close and write-one-to-clear rules, and serves combinational reads.
// Assumes: synchronous active-low reset; err_set comes from the router.
module smram_regs
    import smram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    input  logic       err_set,
    output logic [7:0] cfg_rdata,
    output ctl_t       ctl,
    output ext_t       ext
);

    logic wr_ctl, wr_ext;
    assign wr_ctl = cfg_wr && (cfg_addr == CTL_OFS);
    assign wr_ext = cfg_wr && (cfg_addr == EXT_OFS);

    // Purpose: update the control register under lock and dual-write rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_ctl) begin
            ctl.close  <= cfg_wdata[CTL_CLOSE];
            ctl.gen_en <= cfg_wdata[CTL_GEN];
            if (!ctl.lock) begin
                if (cfg_wdata[CTL_LOCK]) begin
                    ctl.lock <= 1'b1;
                    ctl.open <= 1'b0;
                end else if (!(cfg_wdata[CTL_OPEN] && cfg_wdata[CTL_CLOSE])) begin
                    ctl.open <= cfg_wdata[CTL_OPEN];
                end
            end
        end
    end

    // Purpose: update the extended register; error is sticky, W1C, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext <= '0;
        end else begin
            if (wr_ext) begin
                ext.hi_en <= cfg_wdata[EXT_HI];
                ext.tsz   <= cfg_wdata[EXT_SZ +: 2];
                ext.ts_en <= cfg_wdata[EXT_TS];
            end
            if (err_set)
                ext.err <= 1'b1;
            else if (wr_ext && cfg_wdata[EXT_ERR])
                ext.err <= 1'b0;
        end
    end

    // Purpose: combinational read mux over the two registers.
    always_comb begin
        case (cfg_addr)
            CTL_OFS: cfg_rdata = {1'b0, ctl.open, ctl.close, ctl.lock, ctl.gen_en, BASE_CODE};
            EXT_OFS: cfg_rdata = {ext.hi_en, ext.err, 3'b000, ext.tsz, ext.ts_en};
            default: cfg_rdata = 8'h00;
        endcase
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.lock |=> ctl.lock); // R10
    AST_LOCK_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.lock |-> !ctl.open); // R10
    AST_DUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && cfg_wdata[CTL_OPEN] && cfg_wdata[CTL_CLOSE] && !cfg_wdata[CTL_LOCK])
        |=> $stable(ctl.open)); // R11
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> ext.err); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ext.err && !(wr_ext && cfg_wdata[EXT_ERR])) |=> ext.err); // R9

endmodule

// File: rtl/smram_decode.sv
// Module: smram_decode
// Classifies an address against the fixed low window, the relocated high
// window and the top-of-memory segment. Purely combinational.
// Assumes: tom is at least the largest segment size (no wrap below zero).
module smram_decode #(
    parameter int               AW         = 32,
    parameter logic [AW-1:0]    LOW_BASE   = 32'h000A_0000,
    parameter logic [AW-1:0]    HI_BASE    = 32'h100A_0000,
    parameter int               WIN_BYTES  = 32'h0002_0000,
    parameter int               TSEG_UNIT  = 32'h0002_0000,
    parameter int               TSEG_CODES = 3
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] tom,
    input  logic          hi_en,
    input  logic          ts_en,
    input  logic [1:0]    tsz,
    output logic          low_hit,
    output logic          ext_hit
);

    localparam logic [AW-1:0] WIN_SZ = AW'(WIN_BYTES);

    logic                  hi_hit, ts_hit;
    logic [TSEG_CODES-1:0] code_hit;

    // Purpose: fixed and relocated window range compares.
    always_comb begin
        low_hit = (addr >= LOW_BASE) && (addr < LOW_BASE + WIN_SZ);
        hi_hit  = hi_en && (addr >= HI_BASE) && (addr < HI_BASE + WIN_SZ);
    end

    // one range compare per legal segment size code
    for (genvar g = 0; g < TSEG_CODES; g++) begin : g_tseg
        localparam logic [AW-1:0] SZ = AW'(TSEG_UNIT) << g;
        assign code_hit[g] = (addr < tom) && (addr >= tom - SZ);
    end

    // Purpose: select the compare for the programmed size code.
    always_comb begin
        ts_hit = 1'b0;
        for (int k = 0; k < TSEG_CODES; k++)
            if (tsz == 2'(k)) ts_hit = ts_en && code_hit[k];
    end

    assign ext_hit = hi_hit || ts_hit;

endmodule

// File: rtl/smram_route.sv
// Module: smram_route
// Applies the access policy (enable, open, close, SMM) to window hits and
// registers the routing decision; flags illegal extended-window accesses.
// Assumes: hit inputs are valid in the same cycle as acc_valid.
module smram_route (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_valid,
    input  logic acc_smm,
    input  logic low_hit,
    input  logic ext_hit,
    input  logic open,
    input  logic close,
    input  logic gen_en,
    output logic err_set,
    output logic dec_valid,
    output logic route_dram,
    output logic route_pci
);

    logic in_win, allow, to_dram;

    // Purpose: policy decision for the current access.
    always_comb begin
        in_win  = low_hit || ext_hit;
        allow   = gen_en && (open || (!close && acc_smm));
        to_dram = !in_win || allow;
        err_set = acc_valid && ext_hit && !open;
    end

    // Purpose: register the decision one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            route_dram <= 1'b0;
            route_pci  <= 1'b0;
        end else begin
            dec_valid  <= acc_valid;
            route_dram <= acc_valid && to_dram;
            route_pci  <= acc_valid && !to_dram;
        end
    end

    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $onehot({route_dram, route_pci})); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !(route_dram || route_pci)); // R3
    AST_GEN_OFF_PCI: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !gen_en && (low_hit || ext_hit)) |=> route_pci); // R4
    AST_CLOSE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !open && close && (low_hit || ext_hit)) |=> route_pci); // R6

endmodule

// File: rtl/smram_window_ctrl.sv
// Module: smram_window_ctrl (top)
// Routes memory accesses in SMRAM windows to DRAM or PCI under the control
// of two configuration registers. Decision is registered, one cycle latency.
// Assumes: synchronous active-low reset; tom >= 512 KB.
module smram_window_ctrl #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [7:0]    cfg_addr,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    input  logic          acc_smm,
    input  logic [AW-1:0] tom,
    output logic          dec_valid,
    output logic          route_dram,
    output logic          route_pci
);
    import smram_pkg::*;

    ctl_t ctl;
    ext_t ext;
    logic low_hit, ext_hit, err_set;

    smram_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .err_set   (err_set),
        .cfg_rdata (cfg_rdata),
        .ctl       (ctl),
        .ext       (ext)
    );

    smram_decode #(.AW(AW)) u_dec (
        .addr    (acc_addr),
        .tom     (tom),
        .hi_en   (ext.hi_en),
        .ts_en   (ext.ts_en),
        .tsz     (ext.tsz),
        .low_hit (low_hit),
        .ext_hit (ext_hit)
    );

    smram_route u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_smm    (acc_smm),
        .low_hit    (low_hit),
        .ext_hit    (ext_hit),
        .open       (ctl.open),
        .close      (ctl.close),
        .gen_en     (ctl.gen_en),
        .err_set    (err_set),
        .dec_valid  (dec_valid),
        .route_dram (route_dram),
        .route_pci  (route_pci)
    );

endmodule

// File: tb/smram_window_ctrl_test.sv
`timescale 1ns/1ps
module smram_window_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h72;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_smm = 1'b0;
    logic [31:0] tom = 32'h0800_0000;
    logic        dec_valid, route_dram, route_pci;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // behavioural reference state
    int m_open = 0, m_close = 0, m_lock = 0, m_gen = 0;
    int m_hi = 0, m_err = 0, m_tsz = 0, m_ts = 0;
    int e_valid = 0, e_dram = 0, e_pci = 0;

    always #2 clk = ~clk;   // 250 MHz

    smram_window_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_smm(acc_smm), .tom(tom),
        .dec_valid(dec_valid), .route_dram(route_dram), .route_pci(route_pci)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++; failures++;
            $display("FAIL watchdog expired act=%0d exp=<50000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int model_read(input int a);
        if (a == 'h72) return (m_open<<6)|(m_close<<5)|(m_lock<<4)|(m_gen<<3)|2;
        if (a == 'h73) return (m_hi<<7)|(m_err<<6)|(m_tsz<<1)|m_ts;
        return 0;
    endfunction

    // one clock: drive, update the reference at the edge, compare after it
    task automatic step(input string tag, input bit wr, input int wa, input int wd,
                        input bit v, input longint a, input bit smm);
        longint lo, sz, t;
        bit low, ext, win, allow, dram;
        cfg_wr = wr; cfg_addr = 8'(wa); cfg_wdata = 8'(wd);
        acc_valid = v; acc_addr = 32'(a); acc_smm = smm;
        @(posedge clk);
        t   = longint'(tom);
        low = (a >= 'hA0000) && (a <= 'hBFFFF);
        ext = (m_hi != 0) && (a >= 'h100A0000) && (a <= 'h100BFFFF);
        if (m_ts != 0 && m_tsz != 3) begin
            sz = longint'('h20000) << m_tsz;
            if (a >= t - sz && a < t) ext = 1;
        end
        win   = low || ext;
        allow = (m_gen != 0) && ((m_open != 0) || ((m_close == 0) && smm));
        dram  = !win || allow;
        e_valid = v; e_dram = v && dram; e_pci = v && !dram;
        lo = 0;
        if (wr && wa == 'h72) begin
            m_close = (wd >> 5) & 1; m_gen = (wd >> 3) & 1;
            if (m_lock == 0) begin
                if ((wd >> 4) & 1) begin m_lock = 1; m_open = 0; end
                else if (!(((wd >> 6) & 1) && ((wd >> 5) & 1))) m_open = (wd >> 6) & 1;
            end
        end
        if (wr && wa == 'h73) begin
            m_hi = (wd >> 7) & 1; m_tsz = (wd >> 1) & 3; m_ts = wd & 1;
            if ((wd >> 6) & 1) lo = 1;
        end
        if (v && ext && !(allow && 0) && (model_prev_open != 0 ? 0 : 1)) m_err = 1;
        else if (lo != 0) m_err = 0;
        model_prev_open = m_open;
        #1;
        check({tag, " dec_valid"}, dec_valid, e_valid);
        check({tag, " route_dram"}, route_dram, e_dram);
        check({tag, " route_pci"}, route_pci, e_pci);
        check({tag, " rdata"}, cfg_rdata, model_read(wa));
    endtask

    // open value seen by the access in the cycle being modelled
    int model_prev_open = 0;

    task automatic wr_reg(input string tag, input int wa, input int wd);
        step(tag, 1, wa, wd, 0, 0, 0);
    endtask

    task automatic access(input string tag, input longint a, input bit smm);
        step(tag, 0, 'h72, 0, 1, a, smm);
    endtask

    task automatic rd(input string tag, input int wa);
        step(tag, 0, wa, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0; cfg_wr = 0; acc_valid = 0;
        repeat (3) @(posedge clk);
        m_open = 0; m_close = 0; m_lock = 0; m_gen = 0;
        m_hi = 0; m_err = 0; m_tsz = 0; m_ts = 0; model_prev_open = 0;
        #1;
        rst_n = 1;
    endtask

    initial begin
        longint t;
        int lfsr;
        t = longint'(tom);
        do_reset();
        // R1: reset state
        check("R1 dec_valid", dec_valid, 0);
        check("R1 route_dram", route_dram, 0);
        check("R1 route_pci", route_pci, 0);
        rd("R1 ctl", 'h72);
        rd("R1 ext", 'h73);
        rd("R2 unmapped", 'h10);
        wr_reg("R2 base code ignored", 'h72, 'h05);
        wr_reg("R2 ext reserved bits", 'h73, 'h38);
        wr_reg("R2 restore", 'h72, 'h00);
        // R4: global enable clear
        access("R4 low nonsmm", 'hA0000, 0);
        access("R4 low smm", 'hB0000, 1);
        access("R3 ordinary memory", 'h1000, 0);
        // R6: enabled, closed clear
        wr_reg("R6 enable", 'h72, 'h0A);
        access("R6 smm dram", 'hA0000, 1);
        access("R6 nonsmm pci", 'hA0000, 0);
        access("R3 below window", 'h9FFFF, 0);
        access("R3 last byte", 'hBFFFF, 0);
        access("R3 above window", 'hC0000, 0);
        wr_reg("R6 close", 'h72, 'h2A);
        access("R6 close smm pci", 'hA8000, 1);
        // R5: open
        wr_reg("R5 open", 'h72, 'h4A);
        access("R5 open nonsmm", 'hA0000, 0);
        access("R5 open smm", 'hBFFFF, 1);
        // R11: dual write
        wr_reg("R11 dual keeps open", 'h72, 'h6A);
        wr_reg("R11 clear open", 'h72, 'h0A);
        wr_reg("R11 dual keeps closed", 'h72, 'h6A);
        wr_reg("R11 restore", 'h72, 'h0A);
        // R7: high window
        access("R7 disabled high", 'h100A0000, 0);
        rd("R9 no err yet", 'h73);
        wr_reg("R7 enable high", 'h73, 'h80);
        access("R7 high nonsmm", 'h100A0000, 0);
        rd("R9 err set", 'h73);
        access("R7 high smm", 'h100BFFFF, 1);
        access("R7 past high", 'h100C0000, 0);
        wr_reg("R9 w1c", 'h73, 'hC0);
        rd("R9 err cleared", 'h73);
        // R8: top segment
        wr_reg("R8 code0", 'h73, 'h01);
        access("R8 code0 base smm", t - 'h20000, 1);
        access("R8 code0 below", t - 'h20001, 0);
        access("R8 code0 top nonsmm", t - 1, 0);
        access("R8 at tom", t, 0);
        wr_reg("R8 code1", 'h73, 'h03);
        access("R8 code1 base", t - 'h40000, 0);
        wr_reg("R8 code2", 'h73, 'h05);
        access("R8 code2 base", t - 'h80000, 0);
        access("R8 code2 below", t - 'h80001, 0);
        wr_reg("R8 code3 clear err", 'h73, 'h47);
        access("R8 code3 disabled", t - 'h80000, 0);
        rd("R9 no err from disabled", 'h73);
        // R9: set wins over clear
        wr_reg("R9 seg on", 'h73, 'h01);
        step("R9 set wins", 1, 'h73, 'h41, 1, t - 1, 0);
        // R10: lock
        wr_reg("R10 open", 'h72, 'h4A);
        wr_reg("R10 lock clears open", 'h72, 'h5A);
        wr_reg("R10 open ignored", 'h72, 'h4A);
        access("R10 locked nonsmm", 'hA0000, 0);
        access("R10 locked smm", 'hA0000, 1);
        wr_reg("R10 close writable", 'h72, 'h28);
        access("R10 locked close smm", 'hA0000, 1);
        // mixed pseudo-random run against the reference
        lfsr = 'h1ACE;
        for (int i = 0; i < 200; i++) begin
            longint a;
            int sel;
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 'hB400 : 0);
            if (i == 100) do_reset();
            sel = lfsr & 7;
            case (sel)
                0: a = 'hA0000 + (lfsr & 'h1FFFF);
                1: a = 'h9FFFF;
                2: a = 'h100A0000 + (lfsr & 'hFFFF);
                3: a = t - 1 - (lfsr & 'h7FFFF);
                4: a = 'hC0000;
                default: a = lfsr;
            endcase
            if (((lfsr >> 4) & 3) == 0)
                step("R3 mix", 1, ((lfsr >> 6) & 1) ? 'h73 : 'h72, (lfsr >> 8) & 'hEF,
                     (lfsr >> 3) & 1, a, (lfsr >> 7) & 1);
            else
                step("R3 mix", 0, ((lfsr >> 6) & 1) ? 'h73 : 'h72, 0,
                     (lfsr >> 3) & 1, a, (lfsr >> 7) & 1);
        end
        do_reset();
        rd("R1 ctl after reset", 'h72);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule